// File: doc/BRIEF.md
# DV Header Capture Buffer

This block sits on the receive path of an isochronous link and watches the incoming DV packets one 32-bit quadlet at a time. Each packet is framed by a start flag and an end flag. When a packet carries the first DIF block of a frame, meaning its block number is zero, the block writes a six-quadlet header record into a small FIFO. Software reads that FIFO through a show-ahead read port.

The record holds a packet control token built from the isochronous header, followed by the isochronous header itself, the two CIP quadlets and the first two quadlets of the H0 DIF block. Two capture modes are available. In the all-streams mode, every DV channel on the bus is recorded and the token leads the record. In the single-channel mode, only the programmed channel is recorded and the token trails the five header quadlets.

The FIFO only ever accepts whole records. When a qualifying record no longer fits, the buffer freezes and accepts nothing more until software issues a flush. After the flush, the buffer collects the newest headers.

Top module: `dvh_capture`

## Requirements
- R1: After reset, host_avail and host_frozen are low.
- R2: A packet is captured only if bits [15:8] of its fourth quadlet (packet quadlet index 3, the first H0 quadlet) equal zero. The packet quadlets are indexed from 0 at rx_sop. The record is committed on the cycle that quadlet index 4 is accepted.
- R3: With cfg_one_chan low, a record is written in this order: token, quadlet 0 (isochronous header), quadlet 1 (CIP0), quadlet 2 (CIP1), quadlet 3, quadlet 4.
- R4: With cfg_one_chan high, a record is written in this order: quadlets 0 to 4 in arrival order, then the token.
- R5: With cfg_one_chan high, only packets whose isochronous header channel field, bits [13:8] of quadlet 0, equals cfg_chan are captured. With cfg_one_chan low, every channel is captured.
- R6: The token has the tag from bits [15:14] of quadlet 0 in bits [15:14], and the channel in bits [13:8]. Bit 0 is 1 when the tcode in bits [7:4] of quadlet 0 is not 4'hA. All other bits are zero.
- R7: A packet that ends before quadlet index 4 is never captured.
- R8: A qualifying record is written only if at least six of the DEPTH slots are free, counted before any same-cycle read. Otherwise the record is dropped and host_frozen rises on the next cycle.
- R9: While host_frozen is high, no quadlet is written, but reads still drain the FIFO.
- R10: host_flush empties the FIFO and clears host_frozen on the next cycle. It takes priority over any read or capture in the same cycle.
- R11: host_avail is high whenever at least one quadlet is stored. host_data shows the oldest quadlet. host_rd pops it when the FIFO is not empty and has no effect when it is empty.
- R12: The FIFO holds DEPTH quadlets (default 32), and records stay in order when storage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received quadlet valid |
| rx_sop | input | 1 | First quadlet of a packet |
| rx_eop | input | 1 | Last quadlet of a packet |
| rx_data | input | 32 | Received quadlet |
| cfg_one_chan | input | 1 | 1 selects single-channel mode |
| cfg_chan | input | 6 | Channel captured in single-channel mode |
| host_flush | input | 1 | Empty the FIFO and clear the freeze |
| host_rd | input | 1 | Pop the oldest quadlet |
| host_data | output | 32 | Oldest stored quadlet |
| host_avail | output | 1 | At least one quadlet is stored |
| host_frozen | output | 1 | A record was dropped; capture is stopped |

## Verification
The assertions assume that rx_sop and rx_eop are only raised together with rx_valid. They also assume that every packet starts with rx_sop. Under those assumptions, at most one commit request appears per packet. The bench drives packets only through a task that builds well-formed frames with correct flags. Idle gaps and reads are interleaved freely, and short packets are sent deliberately to exercise the assumptions' edge. host_rd and host_flush are unconstrained, so reads on an empty FIFO and flushes coinciding with commits are both driven.

// File: rtl/dvh_pkg.sv
package dvh_pkg;
  localparam int REC_QUADS = 6;
  localparam int HDR_QUADS = 5;
  localparam int DBN_IDX   = 3;
  localparam logic [3:0] ISO_TCODE = 4'hA;

  typedef logic [31:0] quad_t;

  typedef struct packed {
    logic [15:0] dlen;
    logic [1:0]  tag;
    logic [5:0]  chan;
    logic [3:0]  tcode;
    logic [3:0]  sy;
  } iso_hdr_t;

  function automatic quad_t make_token(input quad_t iso);
    iso_hdr_t h;
    h = iso_hdr_t'(iso);
    return {16'h0000, h.tag, h.chan, 7'h00, (h.tcode != ISO_TCODE)};
  endfunction

  function automatic logic [7:0] dbn_of(input quad_t h0a);
    return h0a[15:8];
  endfunction

  function automatic logic [5:0] chan_of(input quad_t iso);
    iso_hdr_t h;
    h = iso_hdr_t'(iso);
    return h.chan;
  endfunction
endpackage

// File: rtl/dvh_rx_parse.sv
module dvh_rx_parse
  import dvh_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic                       rx_sop,
  input  logic                       rx_eop,
  input  logic [31:0]                rx_data,
  input  logic                       cfg_one_chan,
  input  logic [5:0]                 cfg_chan,
  output logic                       cap_req,
  output quad_t [REC_QUADS-1:0]      cap_rec
);
  localparam logic [2:0] IDX_DEAD = 3'd7;
  localparam logic [2:0] IDX_LAST = 3'(HDR_QUADS - 1);

  logic [2:0] idx_q, cur_idx, idx_nx;
  quad_t      hdr_q   [HDR_QUADS-1];
  quad_t      hdr_all [HDR_QUADS];
  quad_t      token;
  logic       at_last_hdr, dbn_zero, chan_ok;

  assign cur_idx     = rx_sop ? 3'd0 : idx_q;
  assign at_last_hdr = rx_valid && (cur_idx == IDX_LAST);

  always_comb begin
    if (!rx_valid)                  idx_nx = idx_q;
    else if (rx_eop)                idx_nx = IDX_DEAD;
    else if (cur_idx < IDX_LAST + 3'd1) idx_nx = cur_idx + 3'd1;
    else                            idx_nx = cur_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= IDX_DEAD;
    else        idx_q <= idx_nx;
  end

  always_ff @(posedge clk) begin
    if (rx_valid && cur_idx < IDX_LAST)
      hdr_q[cur_idx[1:0]] <= rx_data;
  end

  genvar g;
  generate
    for (g = 0; g < HDR_QUADS - 1; g++) begin : g_hdr
      assign hdr_all[g] = hdr_q[g];
    end
  endgenerate
  assign hdr_all[HDR_QUADS-1] = rx_data;

  assign token    = make_token(hdr_q[0]);
  assign dbn_zero = (dbn_of(hdr_q[DBN_IDX]) == 8'h00);
  assign chan_ok  = !cfg_one_chan || (chan_of(hdr_q[0]) == cfg_chan);
  assign cap_req  = at_last_hdr && dbn_zero && chan_ok;

  generate
    for (g = 0; g < REC_QUADS; g++) begin : g_rec
      if (g == 0) begin : g_first
        assign cap_rec[g] = cfg_one_chan ? hdr_all[0] : token;
      end else if (g == REC_QUADS - 1) begin : g_lastq
        assign cap_rec[g] = cfg_one_chan ? token : hdr_all[g-1];
      end else begin : g_mid
        assign cap_rec[g] = cfg_one_chan ? hdr_all[g] : hdr_all[g-1];
      end
    end
  endgenerate

  AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |-> rx_valid && !rx_sop); // R2
  AST_ONE_REQ_PER_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |=> !cap_req); // R7
endmodule

// File: rtl/dvh_hdr_fifo.sv
module dvh_hdr_fifo
  import dvh_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_req,
  input  quad_t [REC_QUADS-1:0] wr_rec,
  input  logic                  rd_req,
  output quad_t                 rd_data,
  output logic                  avail,
  output logic                  frozen
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  quad_t         mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] lvl;
  logic          fits, wr_go, ovf_evt, rd_go;

  function automatic logic [PW-1:0] slot(input logic [PW-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return s[PW-1:0];
  endfunction

  function automatic logic [LW-1:0] next_lvl(input logic [LW-1:0] l,
                                             input logic w, input logic r);
    int t;
    t = int'(l) + (w ? REC_QUADS : 0) - (r ? 1 : 0);
    return t[LW-1:0];
  endfunction

  assign fits    = (int'(lvl) + REC_QUADS) <= DEPTH;
  assign wr_go   = wr_req && !frozen && fits && !flush;
  assign ovf_evt = wr_req && !frozen && !fits && !flush;
  assign rd_go   = rd_req && (lvl != '0) && !flush;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int k = 0; k < REC_QUADS; k++)
        mem[slot(wp, k)] <= wr_rec[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; lvl <= '0; frozen <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; lvl <= '0; frozen <= 1'b0;
    end else begin
      if (wr_go)   wp <= slot(wp, REC_QUADS);
      if (rd_go)   rp <= slot(rp, 1);
      if (ovf_evt) frozen <= 1'b1;
      lvl <= next_lvl(lvl, wr_go, rd_go);
    end
  end

  assign rd_data = mem[rp];
  assign avail   = (lvl != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl) <= DEPTH); // R12
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !avail && !frozen); // R10
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !flush |=> frozen); // R9
  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !flush |=> lvl <= $past(lvl)); // R9
  AST_AVAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> avail); // R11
endmodule

// File: rtl/dvh_capture.sv
module dvh_capture
  import dvh_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic [31:0] rx_data,
  input  logic        cfg_one_chan,
  input  logic [5:0]  cfg_chan,
  input  logic        host_flush,
  input  logic        host_rd,
  output logic [31:0] host_data,
  output logic        host_avail,
  output logic        host_frozen
);
  logic                  cap_req;
  quad_t [REC_QUADS-1:0] cap_rec;

  dvh_rx_parse u_parse (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .rx_data      (rx_data),
    .cfg_one_chan (cfg_one_chan),
    .cfg_chan     (cfg_chan),
    .cap_req      (cap_req),
    .cap_rec      (cap_rec)
  );

  dvh_hdr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (host_flush),
    .wr_req  (cap_req),
    .wr_rec  (cap_rec),
    .rd_req  (host_rd),
    .rd_data (host_data),
    .avail   (host_avail),
    .frozen  (host_frozen)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !host_avail && !host_frozen); // R1
endmodule

// File: tb/sim_dvh_capture.sv
`timescale 1ns/1ps
module sim_dvh_capture;
  localparam int DEPTH = 32;

  logic        clk = 0, rst_n = 0;
  logic        rx_valid = 0, rx_sop = 0, rx_eop = 0;
  logic [31:0] rx_data = 0;
  logic        cfg_one_chan = 0;
  logic [5:0]  cfg_chan = 0;
  logic        host_flush = 0, host_rd = 0;
  logic [31:0] host_data;
  logic        host_avail, host_frozen;

  always #4 clk = ~clk;

  dvh_capture #(.DEPTH(DEPTH)) u0 (.*);

  int     vecs = 0, errs = 0;
  string  cur_req = "R1";
  logic [31:0] q [$];
  logic   m_frozen = 0;
  int     m_idx = -1;
  logic [31:0] m_hdr [5];
  int     seed = 100;

  task automatic compare();
    logic exp_av;
    exp_av = (q.size() > 0);
    vecs++;
    if (host_avail !== exp_av || host_frozen !== m_frozen ||
        (exp_av && host_data !== q[0])) begin
      errs++;
      $display("FAIL %s: avail=%b frozen=%b data=%h expected avail=%b frozen=%b data=%h",
               cur_req, host_avail, host_frozen, host_data, exp_av, m_frozen,
               exp_av ? q[0] : 32'h0);
    end
  endtask

  task automatic model_edge();
    int pre, idx;
    logic [31:0] tok;
    logic take;
    take = 0;
    if (rx_valid) begin
      idx = rx_sop ? 0 : m_idx;
      if (idx >= 0 && idx < 5) m_hdr[idx] = rx_data;
      if (idx == 4 && m_hdr[3][15:8] == 8'd0 &&
          (!cfg_one_chan || m_hdr[0][13:8] == cfg_chan)) take = 1;
      if (rx_eop) m_idx = -1;
      else if (idx >= 0) m_idx = (idx < 5) ? idx + 1 : idx;
      else m_idx = -1;
    end
    if (host_flush) begin
      q.delete(); m_frozen = 0;
    end else begin
      pre = q.size();
      if (host_rd && pre > 0) void'(q.pop_front());
      if (take && !m_frozen) begin
        if (pre + 6 <= DEPTH) begin
          tok = {16'd0, m_hdr[0][15:14], m_hdr[0][13:8], 7'd0, (m_hdr[0][7:4] != 4'hA)};
          if (!cfg_one_chan) q.push_back(tok);
          for (int i = 0; i < 5; i++) q.push_back(m_hdr[i]);
          if (cfg_one_chan) q.push_back(tok);
        end else m_frozen = 1;
      end
    end
  endtask

  task automatic step(input logic v, s, e, input logic [31:0] d, input logic rd, fl);
    @(negedge clk);
    compare();
    rx_valid = v; rx_sop = s; rx_eop = e; rx_data = d; host_rd = rd; host_flush = fl;
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 32'h0, 0, 0);
  endtask

  task automatic send_pkt(input logic [5:0] ch, input logic [1:0] tag, input logic [3:0] tc,
                          input logic [7:0] dbn, input int nq, input logic rdmix,
                          input logic fl4);
    logic [31:0] d;
    for (int i = 0; i < nq; i++) begin
      seed++;
      if (i == 0)      d = {16'd480, tag, ch, tc, 4'h0};
      else if (i == 3) d = {8'h1F, seed[7:0], dbn, 8'hA5};
      else             d = 32'h5A00_0000 ^ (seed * 32'h0101_0103);
      step(1, i == 0, i == nq - 1, d, rdmix && (i % 3 == 1), fl4 && i == 4);
    end
    idle(1);
  endtask

  task automatic drain();
    int g = 0;
    while (q.size() > 0 && g < 200) begin step(0, 0, 0, 0, 1, 0); g++; end
    step(0, 0, 0, 0, 1, 0);  // R11 read on empty has no effect
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; idle(2);
    cur_req = "R3"; send_pkt(6'd5, 2'd1, 4'hA, 8'd0, 12, 0, 0); drain();
    cur_req = "R2"; send_pkt(6'd5, 2'd1, 4'hA, 8'd3, 12, 0, 0);
    send_pkt(6'd9, 2'd1, 4'hA, 8'd0, 10, 1, 0); drain();
    cur_req = "R6"; send_pkt(6'd63, 2'd3, 4'h7, 8'd0, 8, 0, 0);
    send_pkt(6'd0, 2'd0, 4'hA, 8'd0, 6, 1, 0); drain();
    cur_req = "R7"; send_pkt(6'd5, 2'd1, 4'hA, 8'd0, 4, 0, 0);
    send_pkt(6'd5, 2'd1, 4'hA, 8'd0, 1, 0, 0); idle(2);
    cur_req = "R4"; cfg_one_chan = 1; cfg_chan = 6'd12;
    send_pkt(6'd12, 2'd2, 4'hA, 8'd0, 9, 0, 0); drain();
    cur_req = "R5"; send_pkt(6'd13, 2'd2, 4'hA, 8'd0, 9, 0, 0);
    send_pkt(6'd12, 2'd2, 4'hA, 8'd1, 9, 0, 0);
    send_pkt(6'd12, 2'd0, 4'h3, 8'd0, 9, 0, 0); drain();
    cfg_one_chan = 0;
    send_pkt(6'd13, 2'd2, 4'hA, 8'd0, 7, 0, 0); drain();
    cur_req = "R8";
    for (int r = 0; r < 6; r++) send_pkt(6'(r), 2'd1, 4'hA, 8'd0, 7, 0, 0);
    cur_req = "R9"; step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
    send_pkt(6'd2, 2'd1, 4'hA, 8'd0, 7, 0, 0);
    cur_req = "R10"; step(0, 0, 0, 0, 1, 1); idle(2);
    send_pkt(6'd4, 2'd1, 4'hA, 8'd0, 7, 0, 0);
    send_pkt(6'd4, 2'd1, 4'hA, 8'd0, 7, 0, 1); idle(1);
    step(0, 0, 0, 0, 0, 1); idle(1);
    cur_req = "R12";
    for (int r = 0; r < 4; r++) send_pkt(6'(r + 20), 2'd0, 4'hA, 8'd0, 8, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0);
    for (int r = 0; r < 4; r++) send_pkt(6'(r + 30), 2'd0, 4'hA, 8'd0, 8, 1, 0);
    cur_req = "R11"; drain(); idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule